// File: doc/BRIEF.md
# On-Demand Clock Request Gate

This block decides whether one clock source is allowed to reach its consumers. Peripherals raise request lines when they need the clock. While none of them does, the source is held stopped to save power. A new request restarts it, and the clock is reported ready only after a programmable startup count has elapsed. When the last request drops, the clock keeps running for a bounded grace period before it is gated off. A request that returns inside that period cancels the shutdown.

The source can be divided by a programmable value. The output is a clean pulse train that is gated through a latch that is transparent while the source clock is low. The on-demand behaviour can be switched off so that the source never stops. In standby the request path works only when the run-in-standby bit is set. The ready status is brought into the consumer clock domain through two flops.

Top module: `ondemand_clk_gate`

## Requirements
- R1: While `rst_n` is low, `clk_out` stays low and `clk_rdy` reads 0.
- R2: A `div_sel` value of 0 or 1 passes one output pulse per source cycle. A value d of 2 or more passes exactly one output pulse per d source cycles.
- R3: With the clock stopped, a request seen at source edge 1 gives ready in the source domain at edge startup_cnt+2. No output pulse occurs before that edge.
- R4: After the last request drops, the clock stops at source edge d+2, where d is the effective divide value. This lies between d+1 and 2d+2 source cycles.
- R5: With `ondemand_en` at 0, the clock keeps running and ready stays 1 whatever the requests do. A new request then shows no startup delay.
- R6: In standby (`stby`=1) with `run_stby`=0, the clock stops after the same countdown as R4 and stays stopped. With `run_stby`=1, requests start it as in R3.
- R7: A request that returns while the stop countdown runs cancels it. Ready stays 1 and pulses continue with no new startup.
- R8: `clk_rdy` follows the source-domain ready state through two `clk_cpu` flops, so every change appears two consumer edges later.
- R9: Once the clock is stopped, `clk_out` shows no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| clk_cpu | input | 1 | Consumer-domain clock for the ready status |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | DIV_W | Divide value (0 or 1 = undivided) |
| startup_cnt | input | SU_W | Startup delay in source cycles |
| req | input | NREQ | Clock request lines, one per peripheral |
| ondemand_en | input | 1 | 1 = stop the clock when unrequested |
| run_stby | input | 1 | 1 = keep request handling alive in standby |
| stby | input | 1 | Standby indication |
| clk_out | output | 1 | Gated, divided clock |
| clk_rdy | output | 1 | Clock-ready status in the `clk_cpu` domain |

## Verification
Stimulus changes on a falling edge, so source edge 1 is the first rising edge after the change. Ready is due at `clk_rdy` two consumer edges after its source-domain edge. That makes a start visible after startup_cnt+4 edges and a stop after d+4 edges. The driver queues each expected ready level with the cycle on which it is due, together with the cycle just before it. The monitor compares these on falling edges. Pulse counts are taken over whole windows of d source cycles, opened only after the divider has settled.

// File: rtl/odc_pkg.sv
package odc_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_ON    = 2'd2,
    ST_STOP  = 2'd3
  } odc_state_e;
endpackage

// File: rtl/odc_divider.sv
module odc_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic [DIV_W-1:0] div_eff,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign div_eff = (div_sel < DIV_W'(2)) ? DIV_W'(1) : div_sel;

  always_comb begin
    if (!run)                          cnt_n = '0;
    else if (cnt_q >= div_eff - 1'b1)  cnt_n = '0;
    else                               cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = run && (cnt_q == '0);

  // R2: a divided tick is never followed directly by another when d > 1
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_eff > DIV_W'(1) && $stable(div_sel)) |=> !tick);
endmodule

// File: rtl/odc_ctrl.sv
module odc_ctrl
  import odc_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SU_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want,
  input  logic [SU_W-1:0]  startup_cnt,
  input  logic [DIV_W-1:0] div_eff,
  output logic             running
);
  localparam int TW = (SU_W > DIV_W) ? SU_W : DIV_W;

  odc_state_e    state_q, state_n;
  logic [TW-1:0] tmr_q, tmr_n;

  always_comb begin
    state_n = state_q;
    tmr_n   = tmr_q;
    case (state_q)
      ST_OFF: if (want) begin
        state_n = ST_START;
        tmr_n   = TW'(startup_cnt);
      end
      ST_START: begin
        if (tmr_q == '0) state_n = ST_ON;
        else             tmr_n   = tmr_q - 1'b1;
      end
      ST_ON: if (!want) begin
        state_n = ST_STOP;
        tmr_n   = TW'(div_eff);
      end
      ST_STOP: begin
        if (want)              state_n = ST_ON;
        else if (tmr_q == '0)  state_n = ST_OFF;
        else                   tmr_n   = tmr_q - 1'b1;
      end
      default: state_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      tmr_q   <= '0;
    end else begin
      state_q <= state_n;
      tmr_q   <= tmr_n;
    end
  end

  assign running = (state_q == ST_ON) || (state_q == ST_STOP);

  // R3: startup is not cut short
  p_start_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tmr_q != '0) |=> state_q == ST_START);
  // R4: the clock only stops after the countdown expires
  p_stop_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(state_q) == ST_STOP && $past(tmr_q) == '0));
  // R7: a returning request cancels the countdown
  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && want) |=> state_q == ST_ON);
  // R5: a running, wanted clock stays running
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && want) |=> running);
endmodule

// File: rtl/odc_gate.sv
module odc_gate (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en,
  output logic clk_o
);
  logic en_lat;

  always_latch begin
    if (!rst_n)      en_lat = 1'b0;
    else if (!clk_i) en_lat = en;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/odc_sync.sv
module odc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      q    <= 1'b0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/ondemand_clk_gate.sv
module ondemand_clk_gate #(
  parameter int NREQ  = 4,
  parameter int DIV_W = 8,
  parameter int SU_W  = 8
) (
  input  logic             clk_src,
  input  logic             clk_cpu,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [SU_W-1:0]  startup_cnt,
  input  logic [NREQ-1:0]  req,
  input  logic             ondemand_en,
  input  logic             run_stby,
  input  logic             stby,
  output logic             clk_out,
  output logic             clk_rdy
);
  logic             want;
  logic             running;
  logic             tick;
  logic [DIV_W-1:0] div_eff;

  assign want = (!stby || run_stby) && (!ondemand_en || (|req));

  odc_ctrl #(.DIV_W(DIV_W), .SU_W(SU_W)) u_ctrl (
    .clk(clk_src), .rst_n(rst_n), .want(want),
    .startup_cnt(startup_cnt), .div_eff(div_eff), .running(running)
  );

  odc_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk_src), .rst_n(rst_n), .run(running),
    .div_sel(div_sel), .div_eff(div_eff), .tick(tick)
  );

  odc_gate u_gate (
    .clk_i(clk_src), .rst_n(rst_n), .en(tick), .clk_o(clk_out)
  );

  odc_sync u_sync (
    .clk(clk_cpu), .rst_n(rst_n), .d(running), .q(clk_rdy)
  );

  // R6: without run-in-standby a stopped clock stays stopped in standby
  p_stby_stop_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
    (stby && !run_stby && !running) |=> !running);
  // R8: a rise of the consumer-domain ready follows source ready
  p_sync_lag_r8: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $rose(clk_rdy) |-> $past(running, 2));
endmodule

// File: tb/ondemand_clk_gate_tb.sv
module ondemand_clk_gate_tb;
  localparam int NREQ = 4, DIV_W = 8, SU_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] div_sel;
  logic [SU_W-1:0]  startup_cnt;
  logic [NREQ-1:0]  req;
  logic             ondemand_en, run_stby, stby;
  logic             clk_out, clk_rdy;

  always #4 clk = ~clk;

  ondemand_clk_gate #(.NREQ(NREQ), .DIV_W(DIV_W), .SU_W(SU_W)) u_dut (
    .clk_src(clk), .clk_cpu(clk), .rst_n(rst_n), .div_sel(div_sel),
    .startup_cnt(startup_cnt), .req(req), .ondemand_en(ondemand_en),
    .run_stby(run_stby), .stby(stby), .clk_out(clk_out), .clk_rdy(clk_rdy)
  );

  typedef struct { int due; bit exp; string tag; } item_t;
  item_t sb[$];
  int cyc = 0, pulses = 0, n_chk = 0, n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk_out) pulses <= pulses + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver side: queue an expected ready level for a given cycle
  task automatic expect_rdy(int due, bit v, string tag);
    item_t it;
    it.due = due; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare at the falling edge of the due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      check(clk_rdy == it.exp, it.tag, int'(clk_rdy), int'(it.exp));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_window(int n, int exp, string tag);
    pulses = 0;
    step(n);
    check(pulses == exp, tag, pulses, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int c;
    rst_n = 1'b0; div_sel = '0; startup_cnt = 8'd5; req = '0;
    ondemand_en = 1'b1; run_stby = 1'b0; stby = 1'b0;
    step(3);
    check(clk_out == 1'b0, "R1 clk_out in reset", int'(clk_out), 0);
    check(clk_rdy == 1'b0, "R1 clk_rdy in reset", int'(clk_rdy), 0);
    rst_n = 1'b1;
    step(2);
    pulse_window(10, 0, "R9 idle no pulses");

    // R3 / R8: startup of 5
    pulses = 0;
    c = cyc; req[1] = 1'b1;
    expect_rdy(c + 8, 1'b0, "R8 rdy before sync lag");
    expect_rdy(c + 9, 1'b1, "R3 rdy after startup");
    while (cyc < c + 7) step(1);
    check(pulses == 0, "R3 no pulse during startup", pulses, 0);
    step(4);

    // R2: divide ratios
    div_sel = 8'd0; step(4);  pulse_window(4, 4, "R2 div 0");
    div_sel = 8'd1; step(4);  pulse_window(4, 4, "R2 div 1");
    div_sel = 8'd3; step(6);  pulse_window(12, 4, "R2 div 3");
    div_sel = 8'd5; step(10); pulse_window(20, 4, "R2 div 5");

    // R4: stop after drop with d=3
    div_sel = 8'd3; step(6);
    c = cyc; req = '0;
    expect_rdy(c + 6, 1'b1, "R4 still running");
    expect_rdy(c + 7, 1'b0, "R4 stopped");
    step(10);
    pulse_window(12, 0, "R9 no pulses when stopped");

    // R7: cancel during countdown
    startup_cnt = 8'd2; div_sel = 8'd2;
    req[0] = 1'b1; step(10);
    c = cyc; req = '0;
    for (int i = 1; i <= 12; i++) expect_rdy(c + i, 1'b1, "R7 rdy held");
    step(2); req[2] = 1'b1;
    step(12);
    pulse_window(8, 4, "R7 pulses continue");

    // R5: on-demand disabled
    ondemand_en = 1'b0; step(2);
    c = cyc; req = '0;
    for (int i = 1; i <= 12; i++) expect_rdy(c + i, 1'b1, "R5 rdy without request");
    step(14);
    pulse_window(8, 4, "R5 pulses without request");
    c = cyc; req[3] = 1'b1;
    for (int i = 1; i <= 3; i++) expect_rdy(c + i, 1'b1, "R5 no startup on request");
    step(4);

    // R6: standby
    ondemand_en = 1'b1; run_stby = 1'b0; step(2);
    c = cyc; stby = 1'b1;
    expect_rdy(c + 5, 1'b1, "R6 countdown in standby");
    expect_rdy(c + 6, 1'b0, "R6 stopped in standby");
    step(10);
    pulse_window(8, 0, "R6 no pulses in standby");
    c = cyc; run_stby = 1'b1;
    expect_rdy(c + 5, 1'b0, "R6 startup in standby");
    expect_rdy(c + 6, 1'b1, "R6 ready in standby");
    step(10);

    finish_run();
  end
endmodule